// File: doc/BRIEF.md
# Ranked Interrupt Vector Select Unit

This block performs the vector-select step of a small 8-bit controller. When the core executes its vector-select instruction, it raises `start` for one cycle. On that cycle it supplies the instruction's own 15-bit address, the set of maskable interrupt sources that are currently active (each already pending and enabled), and a software-trap request. The unit picks the winning source by rank and finds the vector table that belongs to the instruction's 256-byte page. It then reads the two vector bytes from a byte-wide program ROM port and loads a 15-bit program counter from them.

The table holds 2-byte entries at page offsets 0xE0 through 0xFF. An instruction sitting on the last byte of a page uses the table in the following page. A table that would land in page 0 is refused with an error pulse. If nothing is active, the lowest slot acts as the default vector.

The unit also keeps the global interrupt enable flag. A return-from-interrupt pulse sets it, and an interrupt-acceptance pulse from the core clears it.

Top module: `vsel_unit`

## Requirements
- R1: Maskable source bit i of `irq_act` (bit 0 is the lowest rank, bit 13 the highest) has its vector high byte at page offset 0xE0+2i and its low byte at 0xE1+2i. When several bits are set, the highest set bit wins. Maskable selection never produces offset 0xFC or 0xFD.
- R2: `trap_req` outranks every maskable source; its vector high byte is at offset 0xFE and its low byte at 0xFF.
- R3: With no source active at `start`, the vector is read from offsets 0xE0 (high) and 0xE1 (low).
- R4: The table page is bits 14:8 of `instr_addr`, so the ROM address is {page, offset}.
- R5: When `instr_addr[7:0]` is 0xFF, the table page is bits 14:8 plus one, wrapping within 7 bits.
- R6: If the table page is 0, `page_err` pulses high for exactly the cycle after `start`. No ROM read is issued, `pc_load` does not pulse, `busy` stays low and `pc_value` keeps its value.
- R7: With `start` sampled at clock edge k, the high-byte address is driven with `rom_rd` during cycle k..k+1 and the low-byte address during k+1..k+2. `busy` is high from k to k+3. `pc_load` is a one-cycle pulse during k+3..k+4, with the new `pc_value` valid from then on. The ROM returns data one cycle after the address it samples.
- R8: `pc_value` equals {high byte bits 6:0, low byte}; bit 7 of the high byte is dropped.
- R9: The request set, the trap and the instruction address are captured at `start`. Changes during the fetch do not alter the vector read.
- R10: `start` asserted while `busy` is high is ignored: the running fetch completes unchanged and no further fetch follows.
- R11: `gie` resets to 0. `reti_pulse` sets it on the next edge and `gie_clr` clears it; when both are high, `reti_pulse` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Vector-select instruction executes this cycle |
| instr_addr | input | 15 | Address of the vector-select instruction |
| irq_act | input | 14 | Active maskable sources, bit 0 lowest rank |
| trap_req | input | 1 | Software trap request |
| reti_pulse | input | 1 | Return-from-interrupt, sets the enable flag |
| gie_clr | input | 1 | Interrupt accepted, clears the enable flag |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 15 | ROM byte address |
| rom_data | input | 8 | ROM read data, one cycle after address |
| busy | output | 1 | Fetch sequence in progress |
| pc_load | output | 1 | One-cycle program-counter load pulse |
| pc_value | output | 15 | Loaded program counter |
| page_err | output | 1 | Table would fall in page 0 |
| gie | output | 1 | Global interrupt enable flag |

## Verification
The bench drives instructions at a page's last byte, including 0x00FF, which must move legally to page 1. It also drives 0x7FFF, which wraps to page 0 and must be refused. A design that ignores the last-byte rule, or that wraps without checking, reads the wrong page or loads a program counter it should not. Each test runs with the highest rank alone, with many ranks at once, with a trap over every source, and with nothing active. A wrong priority or a missing default would then read the wrong slot.

Two further cases stress capture. The requests are swapped mid-fetch, and a second `start` arrives while `busy` is high. A unit that decodes live inputs would read the trap slot or start a second fetch. ROM high bytes with bit 7 set expose a design that keeps all 16 bits.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    localparam int unsigned PC_W      = 15;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned PAGE_W    = PC_W - BYTE_W;
    localparam int unsigned N_MASK    = 14;

    localparam logic [BYTE_W-1:0] TBL_BASE  = 8'hE0;
    localparam logic [BYTE_W-1:0] TRAP_SLOT = 8'hFE;
    localparam logic [BYTE_W-1:0] LAST_OFS  = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_LOAD = 2'd3
    } vsel_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [BYTE_W-1:0] slot;
    } tbl_ptr_t;

    // Offset of the high byte for maskable rank r.
    function automatic logic [BYTE_W-1:0] rank_slot(input int unsigned r);
        return TBL_BASE + BYTE_W'(2 * r);
    endfunction

    // Page that carries the table for an instruction at addr.
    function automatic logic [PAGE_W-1:0] table_page(input logic [PC_W-1:0] addr);
        logic [PAGE_W-1:0] base;
        base = addr[PC_W-1:BYTE_W];
        if (addr[BYTE_W-1:0] == LAST_OFS) begin
            return base + PAGE_W'(1);
        end
        return base;
    endfunction

endpackage

// File: rtl/vsel_rank_pick.sv
module vsel_rank_pick
    import vsel_pkg::*;
#(
    parameter int unsigned N_SRC = N_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  act,
    input  logic              trap,
    output logic [BYTE_W-1:0] slot
);

    logic [BYTE_W-1:0] cand [N_SRC];

    genvar g;
    generate
        for (g = 0; g < int'(N_SRC); g++) begin : g_cand
            assign cand[g] = rank_slot(g);
        end
    endgenerate

    always_comb begin
        slot = TBL_BASE;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (act[i]) begin
                slot = cand[i];
            end
        end
        if (trap) begin
            slot = TRAP_SLOT;
        end
    end

    // R1
    slot_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (slot[0] == 1'b0) && (slot != 8'hFC) && (slot >= TBL_BASE));

    // R2
    trap_top_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> (slot == 8'hFE));

endmodule

// File: rtl/vsel_page_calc.sv
module vsel_page_calc
    import vsel_pkg::*;
(
    input  logic [PC_W-1:0]   instr_addr,
    output logic [PAGE_W-1:0] page,
    output logic              illegal
);

    always_comb begin
        page    = table_page(instr_addr);
        illegal = (page == '0);
    end

endmodule

// File: rtl/vsel_fetch_fsm.sv
module vsel_fetch_fsm
    import vsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [BYTE_W-1:0] slot_in,
    input  logic              illegal,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              rom_rd,
    output logic [PC_W-1:0]   rom_addr,
    output logic              busy,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_value,
    output logic              page_err
);

    vsel_state_e          state_q;
    tbl_ptr_t             ptr_q;
    logic [BYTE_W-2:0]    hi_q;
    logic [PC_W-1:0]      pc_q;
    logic                 done_q;
    logic                 err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            hi_q    <= '0;
            pc_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (illegal) begin
                            err_q <= 1'b1;
                        end else begin
                            ptr_q.page <= page_in;
                            ptr_q.slot <= slot_in;
                            state_q    <= ST_HI;
                        end
                    end
                end
                ST_HI: begin
                    state_q <= ST_LO;
                end
                ST_LO: begin
                    hi_q    <= rom_data[BYTE_W-2:0];
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    pc_q    <= {hi_q, rom_data};
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rom_rd   = (state_q == ST_HI) || (state_q == ST_LO);
        rom_addr = {ptr_q.page, ptr_q.slot[BYTE_W-1:1], (state_q == ST_LO)};
        busy     = (state_q != ST_IDLE);
        pc_load  = done_q;
        pc_value = pc_q;
        page_err = err_q;
    end

    // R7
    load_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD) |=> (pc_load && !busy));

    // R7
    hi_then_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HI) |=> (rom_rd && rom_addr[0]));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LO && start) |=> (state_q == ST_LOAD));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(ptr_q)));

endmodule

// File: rtl/vsel_unit.sv
module vsel_unit
    import vsel_pkg::*;
#(
    parameter int unsigned N_SRC = N_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W-1:0]   instr_addr,
    input  logic [N_SRC-1:0]  irq_act,
    input  logic              trap_req,
    input  logic              reti_pulse,
    input  logic              gie_clr,
    output logic              rom_rd,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              busy,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_value,
    output logic              page_err,
    output logic              gie
);

    logic [BYTE_W-1:0] sel_slot;
    logic [PAGE_W-1:0] sel_page;
    logic              page_bad;
    logic              gie_q;

    vsel_rank_pick #(.N_SRC(N_SRC)) u_rank (
        .clk  (clk),
        .rst  (rst),
        .act  (irq_act),
        .trap (trap_req),
        .slot (sel_slot)
    );

    vsel_page_calc u_page (
        .instr_addr (instr_addr),
        .page       (sel_page),
        .illegal    (page_bad)
    );

    vsel_fetch_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .page_in  (sel_page),
        .slot_in  (sel_slot),
        .illegal  (page_bad),
        .rom_data (rom_data),
        .rom_rd   (rom_rd),
        .rom_addr (rom_addr),
        .busy     (busy),
        .pc_load  (pc_load),
        .pc_value (pc_value),
        .page_err (page_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else if (reti_pulse) begin
            gie_q <= 1'b1;
        end else if (gie_clr) begin
            gie_q <= 1'b0;
        end
    end

    assign gie = gie_q;

    // R11
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
        reti_pulse |=> gie);

    // R6
    no_page0_read_chk: assert property (@(posedge clk) disable iff (rst)
        rom_rd |-> (rom_addr[PC_W-1:BYTE_W] != '0));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        page_err |-> (!busy && !pc_load && !rom_rd));

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

endmodule

// File: tb/vsel_unit_tb.sv
module vsel_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [14:0] instr_addr;
    logic [13:0] irq_act;
    logic        trap_req;
    logic        reti_pulse;
    logic        gie_clr;
    logic        rom_rd;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data;
    logic        busy;
    logic        pc_load;
    logic [14:0] pc_value;
    logic        page_err;
    logic        gie;

    int n_cmp  = 0;
    int n_miss = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vsel_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .instr_addr (instr_addr),
        .irq_act    (irq_act),
        .trap_req   (trap_req),
        .reti_pulse (reti_pulse),
        .gie_clr    (gie_clr),
        .rom_rd     (rom_rd),
        .rom_addr   (rom_addr),
        .rom_data   (rom_data),
        .busy       (busy),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .page_err   (page_err),
        .gie        (gie)
    );

    function automatic logic [7:0] rom_byte(input logic [14:0] a);
        return (a[7:0] * 8'd29 + {1'b0, a[14:8]}) ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        if (rom_rd) rom_data <= rom_byte(rom_addr);
    end

    function automatic logic [6:0] exp_page(input logic [14:0] ia);
        return (ia[7:0] == 8'hFF) ? ia[14:8] + 7'd1 : ia[14:8];
    endfunction

    function automatic logic [7:0] exp_slot(input logic [13:0] act, input logic trap);
        logic [7:0] s;
        s = 8'hE0;
        for (int i = 0; i < 14; i++) if (act[i]) s = 8'hE0 + 8'(2 * i);
        if (trap) s = 8'hFE;
        return s;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // Monitor: pop expected results as the design reports them.
    always @(negedge clk) begin
        if (!rst && (pc_load || page_err)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected result", {16'd0, page_err, pc_value}, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(page_err == e[15], {t, " err flag"}, int'(page_err), int'(e[15]));
                if (!e[15]) chk(pc_value == e[14:0], {t, " pc"}, int'(pc_value), int'(e[14:0]));
            end
        end
    end

    // Driver: one vector-select operation.
    task automatic issue(input logic [14:0] ia, input logic [13:0] act, input logic trap,
                         input bit swap, input bit dbl, input string tag);
        logic [6:0]  pg;
        logic [7:0]  sl;
        logic [7:0]  hi;
        logic [7:0]  lo;
        pg = exp_page(ia);
        sl = exp_slot(act, trap);
        hi = rom_byte({pg, sl});
        lo = rom_byte({pg, sl | 8'h01});
        exp_q.push_back({(pg == 7'd0), hi[6:0], lo});
        tag_q.push_back(tag);
        @(negedge clk);
        instr_addr = ia; irq_act = act; trap_req = trap; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (pg == 7'd0) begin
            chk(busy == 1'b0 && rom_rd == 1'b0, "R6 no fetch", int'({busy, rom_rd}), 0);
            @(negedge clk);
            chk(page_err == 1'b0, "R6 err one cycle", int'(page_err), 0);
            return;
        end
        if (swap) begin
            irq_act = 14'h0001; trap_req = 1'b1; instr_addr = 15'h5555;
        end
        chk(busy && rom_rd && rom_addr == {pg, sl}, {tag, " R7 hi addr"},
            int'({busy, rom_rd, rom_addr}), int'({2'b11, pg, sl}));
        @(negedge clk);
        if (dbl) start = 1'b1;
        chk(rom_rd && rom_addr == {pg, sl | 8'h01}, {tag, " R7 lo addr"},
            int'({rom_rd, rom_addr}), int'({1'b1, pg, sl | 8'h01}));
        @(negedge clk);
        start = 1'b0;
        chk(busy && !rom_rd, "R7 load cycle", int'({busy, rom_rd}), 2);
        @(negedge clk);
        chk(pc_load && !busy, "R7 done pulse", int'({pc_load, busy}), 2);
        @(negedge clk);
        chk(!pc_load && !busy && !rom_rd, "R10 R7 quiet after", int'({pc_load, busy, rom_rd}), 0);
        trap_req = 1'b0; irq_act = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_miss++;
        $display("FAIL R7 watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; instr_addr = '0; irq_act = '0; trap_req = 1'b0;
        reti_pulse = 1'b0; gie_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !pc_load && !rom_rd && !page_err, "R7 reset outputs",
            int'({busy, pc_load, rom_rd, page_err}), 0);
        chk(pc_value == 15'd0, "R8 reset pc", int'(pc_value), 0);
        chk(gie == 1'b0, "R11 reset gie", int'(gie), 0);

        issue(15'h0345, 14'h0008, 1'b0, 0, 0, "R1 R4 rank3");
        issue(15'h1A10, 14'h2005, 1'b0, 0, 0, "R1 top rank wins");
        issue(15'h0C00, 14'h2000, 1'b0, 0, 0, "R1 R8 slot FA");
        issue(15'h2222, 14'h3FFF, 1'b1, 0, 0, "R2 trap over all");
        issue(15'h0401, 14'h0000, 1'b0, 0, 0, "R3 default slot");
        issue(15'h02FF, 14'h0040, 1'b0, 0, 0, "R5 next page");
        issue(15'h00FF, 14'h0002, 1'b0, 0, 0, "R5 page1 legal");
        issue(15'h0010, 14'h0004, 1'b0, 0, 0, "R6 page zero");
        issue(15'h7FFF, 14'h0000, 1'b1, 0, 0, "R6 wrap to zero");
        issue(15'h1234, 14'h0100, 1'b0, 1, 0, "R9 capture");
        issue(15'h6789, 14'h0020, 1'b0, 0, 1, "R10 start while busy");
        issue(15'h3F7E, 14'h1000, 1'b0, 0, 0, "R8 hi bit dropped");

        @(negedge clk); reti_pulse = 1'b1;
        @(negedge clk); reti_pulse = 1'b0;
        chk(gie == 1'b1, "R11 reti sets", int'(gie), 1);
        gie_clr = 1'b1;
        @(negedge clk); gie_clr = 1'b0;
        chk(gie == 1'b0, "R11 clear", int'(gie), 0);
        reti_pulse = 1'b1; gie_clr = 1'b1;
        @(negedge clk); reti_pulse = 1'b0; gie_clr = 1'b0;
        chk(gie == 1'b1, "R11 reti wins", int'(gie), 1);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule